// File: doc/BRIEF.md
# Four-Lane Parallel Digital Downconverter

This block moves a band-pass-sampled real signal down in frequency. The composite stream runs at 300 MS/s but arrives as four parallel lanes of 75 MS/s each, lane 0 carrying the earliest sample of every group of four. The block does not serialize the stream. Each lane instead multiplies its sample by a local-oscillator sample of its own, and every clock it produces one real, rounded product per lane, with lane order and alignment kept.

A single 32-bit phase accumulator steps by four per-sample increments on every clock. Lane k reads the accumulator plus k increments, so the four generators hold the time skew between lanes. With the carrier at 75.42 MHz and the oscillator set to 60.42 MHz (increment 865006413), the wanted band lands near 15 MHz. An image near 135.84 MHz is left in the output for a later decimating filter to remove. A quarter-wave sine table, addressed by the top ten phase bits, supplies 12-bit signed oscillator values. A new increment can be loaded at any clock without breaking the phase sequence from one sample to the next.

Top module: `quad_lane_mixer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the accumulator, the increment, the output valid and all output lanes to zero. With the increment left at zero after reset, every lane uses phase 0.
- R2: When `inc_we` is high at an edge, `inc_in` is loaded at that edge. Samples presented in the following cycle use the new increment. The accumulator step taken at the write edge still uses the old increment, so the sample phase sequence stays continuous.
- R3: On every clock, whether or not valid is high, the accumulator advances by 4·inc modulo 2^32. The phase of lane k is the accumulator plus k·inc, for k = 0 to 3.
- R4: The oscillator value for phase p (the top 10 bits of the 32-bit lane phase) is round(2047·sin(2π(p+0.5)/1024)), taken from a 256-entry quarter-wave table by mirroring and negation.
- R5: Each lane output is the product of the sample and the oscillator value divided by 64, rounded to nearest with ties away from zero.
- R6: The rounded result saturates to the range -2047 to +2047, so -2048 never appears at a valid output.
- R7: `out_valid` and the output lanes follow the matching `in_valid` and input lanes by exactly two clocks.
- R8: A zero input sample gives a zero output on its lane, whatever the phase.
- R9: Lane k of the input occupies `in_lanes[8k+7:8k]` and lane k of the output occupies `out_lanes[12k+11:12k]`. Lane 0 is the earliest sample in time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| inc_we | input | 1 | Load the per-sample phase increment |
| inc_in | input | 32 | New per-sample phase increment |
| in_valid | input | 1 | Input lanes carry samples |
| in_lanes | input | 32 | Four 8-bit signed samples, lane 0 in the low byte |
| out_valid | output | 1 | Output lanes carry products |
| out_lanes | output | 48 | Four 12-bit signed mixed samples, lane 0 in the low bits |

## Verification
A zero increment pins every lane to phase 0. Small samples, including exact half-LSB ties, then separate round-half-away-from-zero from truncation or half-up rounding. An increment of a quarter turn puts the four lanes on the table's peaks and zero crossings, with full-scale samples of both signs. This tells symmetric saturation apart from plain clipping and catches a lane wired to the wrong phase offset. Random samples with gaps in valid, at the 60.42 MHz setting and after a mid-stream increment change, test the accumulator step, the per-lane offsets, the two-cycle latency and the continuity of phase across a write.

// File: rtl/qlm_pkg.sv
package qlm_pkg;

    // Quarter-wave sine magnitude for entry j of a qdepth-entry table,
    // sampled at entry centres, scaled to amp. Integer Taylor series in Q28.
    function automatic int qsine(input int j, input int qdepth, input int amp);
        longint x;
        longint t;
        longint s;
        x = (64'sd843314857 * longint'(2 * j + 1)) / longint'(4 * qdepth);
        t = x;
        s = x;
        for (int n = 1; n <= 6; n++) begin
            t = (t * x) >>> 28;
            t = (t * x) >>> 28;
            t = -t / longint'((2 * n) * (2 * n + 1));
            s = s + t;
        end
        return int'((s * longint'(amp) + (64'sd1 <<< 27)) >>> 28);
    endfunction

endpackage

// File: rtl/qlm_phase_gen.sv
module qlm_phase_gen #(
    parameter int LANES = 4,
    parameter int PW    = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       inc_we,
    input  logic [PW-1:0]              inc_in,
    output logic [LANES-1:0][PW-1:0]   lane_ph,
    output logic [PW-1:0]              inc_q
);
    localparam logic [PW-1:0] STEP_MUL = PW'(LANES);

    logic [PW-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            inc_q <= '0;
        end else begin
            acc_q <= acc_q + STEP_MUL * inc_q;
            if (inc_we) begin
                inc_q <= inc_in;
            end
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_ph[k] = acc_q + PW'(k) * inc_q;
    end
endmodule

// File: rtl/qlm_sine_lut.sv
module qlm_sine_lut #(
    parameter int AW = 10,
    parameter int OW = 12
) (
    input  logic [AW-1:0]        phase,
    output logic signed [OW-1:0] sine
);
    localparam int QBITS  = AW - 2;
    localparam int QDEPTH = 1 << QBITS;
    localparam int AMP    = (1 << (OW - 1)) - 1;

    logic [OW-2:0]    qtab [QDEPTH];
    logic [1:0]       quad;
    logic [QBITS-1:0] idx;
    logic [QBITS-1:0] addr;
    logic [OW-2:0]    mag;

    for (genvar i = 0; i < QDEPTH; i++) begin : g_tab
        assign qtab[i] = (OW-1)'(qlm_pkg::qsine(i, QDEPTH, AMP));
    end

    always_comb begin
        quad = phase[AW-1 -: 2];
        idx  = phase[QBITS-1:0];
        addr = quad[0] ? ~idx : idx;
        mag  = qtab[addr];
        sine = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end
endmodule

// File: rtl/qlm_mix_round.sv
module qlm_mix_round #(
    parameter int SW    = 8,
    parameter int OW    = 12,
    parameter int SHIFT = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [SW-1:0] samp,
    input  logic signed [OW-1:0] sine,
    output logic signed [OW-1:0] mixed
);
    localparam int PRW = SW + OW;
    localparam logic signed [PRW-1:0] BIAS_POS = PRW'(1 << (SHIFT - 1));
    localparam logic signed [PRW-1:0] BIAS_NEG = BIAS_POS - PRW'(1);
    localparam logic signed [PRW-1:0] LIM_POS  = PRW'((1 << (OW - 1)) - 1);
    localparam logic signed [PRW-1:0] LIM_NEG  = -LIM_POS;

    logic signed [SW-1:0]  samp_q;
    logic signed [OW-1:0]  sine_q;
    logic signed [PRW-1:0] prod;
    logic signed [PRW-1:0] biased;
    logic signed [PRW-1:0] rnd;
    logic signed [OW-1:0]  sat;

    always_comb begin
        prod   = PRW'(samp_q) * PRW'(sine_q);
        biased = prod + (prod[PRW-1] ? BIAS_NEG : BIAS_POS);
        rnd    = biased >>> SHIFT;
        if (rnd > LIM_POS) begin
            sat = LIM_POS[OW-1:0];
        end else if (rnd < LIM_NEG) begin
            sat = LIM_NEG[OW-1:0];
        end else begin
            sat = rnd[OW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= '0;
            sine_q <= '0;
            mixed  <= '0;
        end else begin
            samp_q <= samp;
            sine_q <= sine;
            mixed  <= sat;
        end
    end
endmodule

// File: rtl/quad_lane_mixer.sv
module quad_lane_mixer #(
    parameter int LANES = 4,
    parameter int SW    = 8,
    parameter int OW    = 12,
    parameter int PW    = 32,
    parameter int AW    = 10,
    parameter int SHIFT = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  inc_we,
    input  logic [PW-1:0]         inc_in,
    input  logic                  in_valid,
    input  logic [LANES*SW-1:0]   in_lanes,
    output logic                  out_valid,
    output logic [LANES*OW-1:0]   out_lanes
);
    logic [LANES-1:0][PW-1:0] lane_ph;
    logic [PW-1:0]            inc_q;
    logic                     vld_s1;

    qlm_phase_gen #(.LANES(LANES), .PW(PW)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .inc_we  (inc_we),
        .inc_in  (inc_in),
        .lane_ph (lane_ph),
        .inc_q   (inc_q)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic signed [OW-1:0] sine_w;
        logic signed [OW-1:0] mixed_w;

        qlm_sine_lut #(.AW(AW), .OW(OW)) u_lut (
            .phase (lane_ph[k][PW-1 -: AW]),
            .sine  (sine_w)
        );

        qlm_mix_round #(.SW(SW), .OW(OW), .SHIFT(SHIFT)) u_mix (
            .clk   (clk),
            .rst   (rst),
            .samp  (in_lanes[k*SW +: SW]),
            .sine  (sine_w),
            .mixed (mixed_w)
        );

        assign out_lanes[k*OW +: OW] = mixed_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_s1    <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            vld_s1    <= in_valid;
            out_valid <= vld_s1;
        end
    end
endmodule

// File: rtl/qlm_checker.sv
module qlm_checker #(
    parameter int LANES = 4,
    parameter int SW    = 8,
    parameter int OW    = 12,
    parameter int PW    = 32
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic [LANES*SW-1:0]      in_lanes,
    input logic                     out_valid,
    input logic [LANES*OW-1:0]      out_lanes,
    input logic [LANES-1:0][PW-1:0] lane_ph,
    input logic [PW-1:0]            inc_q
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    // R7: valid travels with a fixed two-clock latency
    assert_valid_latency_R7: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R2, R3: first lane continues one increment after the previous last lane
    assert_phase_continuity_R3: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1) |-> (lane_ph[0] == $past(lane_ph[LANES-1]) + $past(inc_q)));

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // R8: zero sample gives zero product
        assert_zero_in_zero_out_R8: assert property (@(posedge clk) disable iff (rst)
            ((age >= 2'd2) && $past(in_valid, 2) && ($past(in_lanes[k*SW +: SW], 2) == '0))
            |-> (out_lanes[k*OW +: OW] == '0));

        // R6: symmetric saturation never yields the most negative code
        assert_symmetric_sat_R6: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (out_lanes[k*OW +: OW] != {1'b1, {(OW-1){1'b0}}}));
    end
endmodule

bind quad_lane_mixer qlm_checker #(
    .LANES (LANES),
    .SW    (SW),
    .OW    (OW),
    .PW    (PW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_lanes  (in_lanes),
    .out_valid (out_valid),
    .out_lanes (out_lanes),
    .lane_ph   (lane_ph),
    .inc_q     (inc_q)
);

// File: tb/quad_lane_mixer_tb.sv
module quad_lane_mixer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        inc_we = 1'b0;
    logic [31:0] inc_in = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_lanes = '0;
    logic        out_valid;
    logic [47:0] out_lanes;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural model state
    bit [31:0] m_acc;
    bit [31:0] m_inc;
    bit        ev1, ev2;
    bit        ex1, ex2;
    int        e1 [4];
    int        e2 [4];
    string     t1, t2;

    always #2 clk = ~clk;

    quad_lane_mixer u_dut (
        .clk       (clk),
        .rst       (rst),
        .inc_we    (inc_we),
        .inc_in    (inc_in),
        .in_valid  (in_valid),
        .in_lanes  (in_lanes),
        .out_valid (out_valid),
        .out_lanes (out_lanes)
    );

    function automatic int ref_sine(input bit [31:0] ph);
        real v;
        int  p;
        p = int'(ph[31:22]);
        v = 2047.0 * $sin(2.0 * 3.14159265358979 * (real'(p) + 0.5) / 1024.0);
        return (v >= 0.0) ? $rtoi(v + 0.5) : $rtoi(v - 0.5);
    endfunction

    function automatic int ref_mix(input int x, input int s);
        int prod, q, r;
        prod = x * s;
        q = prod / 64;
        r = prod % 64;
        if (2 * (r < 0 ? -r : r) >= 64) q = q + (prod < 0 ? -1 : 1);
        if (q > 2047) q = 2047;
        if (q < -2047) q = -2047;
        return q;
    endfunction

    task automatic report(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit we, input bit [31:0] incv, input bit v,
                        input int xs [4], input string tag, input bit exact);
        @(negedge clk);
        report(out_valid == ev2, "R7 out_valid latency", int'(out_valid), int'(ev2));
        if (ev2) begin
            for (int k = 0; k < 4; k++) begin
                int act, d;
                act = int'($signed(out_lanes[k*12 +: 12]));
                d = act - e2[k];
                if (d < 0) d = -d;
                report(exact ? (d == 0) : (d <= 2), $sformatf("%s R9 lane %0d", t2, k), act, e2[k]);
            end
        end
        ev2 = ev1; ex2 = ex1; e2 = e1; t2 = t1;
        inc_we = we;
        inc_in = incv;
        in_valid = v;
        for (int k = 0; k < 4; k++) begin
            in_lanes[k*8 +: 8] = 8'(xs[k]);
            e1[k] = ref_mix(xs[k], ref_sine(m_acc + 32'(k) * m_inc));
        end
        ev1 = v; ex1 = exact; t1 = tag;
        @(posedge clk);
        m_acc = m_acc + 32'd4 * m_inc;
        if (we) m_inc = incv;
    endtask

    // flush two idle cycles keeping the tolerance mode of pending checks
    task automatic idle(input int n, input bit exact);
        int z [4] = '{0, 0, 0, 0};
        for (int i = 0; i < n; i++) step(1'b0, 32'd0, 1'b0, z, "idle", exact);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int xs [4];
        m_acc = '0; m_inc = '0;
        ev1 = 0; ev2 = 0; ex1 = 1; ex2 = 1;
        t1 = "none"; t2 = "none";
        repeat (3) @(posedge clk);
        @(negedge clk);
        report(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
        report(out_lanes == '0, "R1 reset lanes", int'(out_lanes[31:0]), 0);
        rst = 1'b0;

        // R1, R4, R5: increment zero -> all lanes at phase 0, sine = 6
        xs = '{16, -16, -5, 127};
        step(0, 0, 1, xs, "R1 R5 phase-zero rounding ties", 1);
        xs = '{0, 0, 0, 0};
        step(0, 0, 1, xs, "R8 zero input", 1);
        idle(2, 1);

        // R6, R4: quarter-turn increment puts lanes on 6, 2047, -6, -2047
        step(1, 32'h4000_0000, 0, xs, "idle", 1);
        xs = '{-128, -128, -128, -128};
        step(0, 0, 1, xs, "R6 saturation negative full scale", 1);
        xs = '{127, 127, 127, 127};
        step(0, 0, 1, xs, "R6 saturation positive full scale", 1);
        xs = '{1, 1, -1, 1};
        step(0, 0, 1, xs, "R4 R5 quarter-turn unit samples", 1);
        xs = '{0, 0, 0, 0};
        step(0, 0, 1, xs, "R8 zero at peak", 1);
        idle(2, 1);

        // R3, R7, R9: 60.42 MHz oscillator, random samples, valid gaps
        step(1, 32'd865006413, 0, xs, "idle", 0);
        for (int i = 0; i < 3000; i++) begin
            for (int k = 0; k < 4; k++) xs[k] = int'($urandom_range(255)) - 128;
            step(0, 0, ($urandom_range(3) != 0), xs, "R3 R9 random stream", 0);
        end

        // R2: increment change mid-stream while valid stays high
        for (int i = 0; i < 2000; i++) begin
            bit we;
            we = (i % 257) == 5;
            for (int k = 0; k < 4; k++) xs[k] = int'($urandom_range(255)) - 128;
            step(we, $urandom, 1, xs, "R2 increment change", 0);
        end
        idle(3, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule